// File: doc/BRIEF.md
# Frame PWM with Narrow-Pulse Dithering

This block produces a single pulse-width-modulated output whose effective resolution is finer than its coarse duty step. A prescaler divides the system clock by a selectable power of two to form the PWM clock. Each output frame is 32 PWM clocks long, and frames repeat in groups of eight. A 5-bit coarse duty sets how many PWM clocks at the start of every frame are high. A 3-bit fine-adjust value adds one extra high PWM clock, placed directly after the coarse high time, to that many frames of each group. The frames that receive the extra clock are spread across the group, so the average duty moves in eighths of one coarse step.

Software-side logic writes the three fields through a simple synchronous write port. The division ratio applies at once. The duty and fine values are held pending and become active together at the start of the next group of eight frames, so a frame never carries a mix of old and new settings. A one-cycle strobe marks the first system clock of every frame.

The waveform comes from a small state machine. It has four states: `ST_IDLE` (after reset, before the first PWM clock), `ST_HIGH` (coarse high time), `ST_NARROW` (the single inserted clock) and `ST_LOW` (rest of frame). Its transitions are taken on PWM clock ticks:
- frame-open: from any state into `ST_HIGH` if the duty is non-zero, otherwise into `ST_NARROW` if the frame is picked, otherwise into `ST_LOW`
- coarse-done: `ST_HIGH` to `ST_NARROW` or `ST_LOW` when the slot count reaches the duty
- narrow-done: `ST_NARROW` to `ST_LOW`
- hold-low: `ST_LOW` stays in `ST_LOW` until the next frame-open

Top module: `frame_dither_pwm`

## Requirements
- R1: While `rst_n` is low and after its release, `pwm_out` and `frame_strobe` are 0; reset clears the divide code, the duty and the fine value to 0, and the first PWM clock after reset opens frame 0 of a new group.
- R2: Writing `wr_sel`=0 sets the divide code from `wr_data[1:0]`; the PWM clock is the system clock divided by 2^(code+1), which gives 2, 4, 8 or 16, and the new ratio applies without waiting for a group boundary.
- R3: Every frame lasts exactly 32 PWM clocks, and `frame_strobe` is high for exactly one system clock at the first clock of each frame.
- R4: Writing `wr_sel`=1 sets the coarse duty from `wr_data[4:0]`; in a frame without an inserted pulse, `pwm_out` is high for the first duty PWM clocks of the frame and low for the rest.
- R5: With duty 0 and fine value 0, `pwm_out` stays low for the whole frame.
- R6: Writing `wr_sel`=2 sets the fine value F from `wr_data[2:0]`; frame f (0 to 7 within the group) receives one extra high PWM clock directly after the coarse high time when the 3-bit reversal of f is below F, so F=3 picks frames 0, 4 and 2.
- R7: Duty and fine writes take effect together at the first frame of the next group; frames remaining in the current group keep the old values.
- R8: With duty 31, a picked frame is high for all 32 PWM clocks, and an unpicked frame is high for 31.
- R9: A write with `wr_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one field |
| wr_sel | input | 2 | Field select: 0 divide code, 1 duty, 2 fine value, 3 none |
| wr_data | input | 5 | Write data, low bits used per field |
| pwm_out | output | 1 | Dithered PWM output |
| frame_strobe | output | 1 | One-cycle pulse at the first clock of each frame |

## Verification
A wrong slot or frame counter shows at once in the spacing of `frame_strobe` and in the high time within one frame; a wrong frame number shows as the extra clock landing in the wrong frame and can only be seen across a full group of eight frames. A pending value that is loaded too early or too late shows as the old or new high time in the wrong frames around a group boundary. The bench therefore measures the period and the high time of every frame, in system clocks, over whole groups that begin at a known frame 0. It works out the expected values from the duty, the fine value and the division ratio.

// File: rtl/fdp_pkg.sv
package fdp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HIGH   = 2'd1,
        ST_NARROW = 2'd2,
        ST_LOW    = 2'd3
    } wave_state_e;

    typedef enum logic [1:0] {
        SEL_DIV   = 2'd0,
        SEL_DUTY  = 2'd1,
        SEL_FINE  = 2'd2,
        SEL_NONE  = 2'd3
    } wr_field_e;

endpackage

// File: rtl/fdp_prescaler.sv
module fdp_prescaler #(
    parameter int DIV_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_BITS-1:0] div_code,
    output logic                tick
);
    localparam int CNT_W = 1 << DIV_BITS;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   span_m1;
    logic [CNT_W-1:0] limit;

    // period = 2^(code+1) system clocks
    always_comb begin
        span    = (CNT_W+1)'(2) << div_code;
        span_m1 = span - (CNT_W+1)'(1);
        limit   = span_m1[CNT_W-1:0];
        tick    = (cnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/fdp_regs.sv
module fdp_regs
    import fdp_pkg::*;
#(
    parameter int DIV_BITS   = 2,
    parameter int SLOT_BITS  = 5,
    parameter int FRAME_BITS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [SLOT_BITS-1:0]  wr_data,
    input  logic                  group_load,
    output logic [DIV_BITS-1:0]   div_code,
    output logic [SLOT_BITS-1:0]  act_duty,
    output logic [FRAME_BITS-1:0] act_fine,
    output logic [SLOT_BITS-1:0]  eff_duty,
    output logic [FRAME_BITS-1:0] eff_fine
);
    logic [SLOT_BITS-1:0]  pend_duty;
    logic [FRAME_BITS-1:0] pend_fine;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_code  <= '0;
            pend_duty <= '0;
            pend_fine <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_DIV:  div_code  <= wr_data[DIV_BITS-1:0];
                SEL_DUTY: pend_duty <= wr_data;
                SEL_FINE: pend_fine <= wr_data[FRAME_BITS-1:0];
                default:  ;
            endcase
        end
    end

    // pending values move to active only at a group boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_duty <= '0;
            act_fine <= '0;
        end else if (group_load) begin
            act_duty <= pend_duty;
            act_fine <= pend_fine;
        end
    end

    // values seen by the waveform for the PWM clock being entered
    always_comb begin
        eff_duty = group_load ? pend_duty : act_duty;
        eff_fine = group_load ? pend_fine : act_fine;
    end
endmodule

// File: rtl/fdp_seq.sv
module fdp_seq #(
    parameter int SLOT_BITS  = 5,
    parameter int FRAME_BITS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    output logic [SLOT_BITS-1:0]  slot_nx,
    output logic [FRAME_BITS-1:0] frm_nx,
    output logic                  frame_open,
    output logic                  group_load
);
    logic [SLOT_BITS-1:0]  slot;
    logic [FRAME_BITS-1:0] frm;

    always_comb begin
        frame_open = tick && (slot == '1);
        group_load = frame_open && (frm == '1);
        slot_nx    = slot + SLOT_BITS'(1);
        frm_nx     = frame_open ? frm + FRAME_BITS'(1) : frm;
    end

    // reset parks at the last slot of the last frame so the first tick opens frame 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '1;
            frm  <= '1;
        end else if (tick) begin
            slot <= slot_nx;
            frm  <= frm_nx;
        end
    end
endmodule

// File: rtl/fdp_wave.sv
module fdp_wave
    import fdp_pkg::*;
#(
    parameter int SLOT_BITS  = 5,
    parameter int FRAME_BITS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  frame_open,
    input  logic [SLOT_BITS-1:0]  slot_nx,
    input  logic [FRAME_BITS-1:0] frm_nx,
    input  logic [SLOT_BITS-1:0]  eff_duty,
    input  logic [FRAME_BITS-1:0] eff_fine,
    output wave_state_e           st,
    output logic                  pwm_out,
    output logic                  frame_strobe
);
    wave_state_e           st_nx;
    logic [FRAME_BITS-1:0] frm_rev;
    logic                  pick;
    logic                  strobe_q;

    for (genvar i = 0; i < FRAME_BITS; i++) begin : g_rev
        assign frm_rev[i] = frm_nx[FRAME_BITS-1-i];
    end

    assign pick = (frm_rev < eff_fine);

    always_comb begin
        st_nx = st;
        if (tick) begin
            if (frame_open) begin
                if (eff_duty != '0) begin
                    st_nx = ST_HIGH;
                end else if (pick) begin
                    st_nx = ST_NARROW;
                end else begin
                    st_nx = ST_LOW;
                end
            end else begin
                unique case (st)
                    ST_IDLE:   st_nx = ST_IDLE;
                    ST_HIGH:   if (slot_nx == eff_duty) st_nx = pick ? ST_NARROW : ST_LOW;
                    ST_NARROW: st_nx = ST_LOW;
                    ST_LOW:    st_nx = ST_LOW;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            strobe_q <= 1'b0;
        end else begin
            st       <= st_nx;
            strobe_q <= frame_open;
        end
    end

    always_comb begin
        pwm_out      = (st == ST_HIGH) || (st == ST_NARROW);
        frame_strobe = strobe_q;
    end
endmodule

// File: rtl/frame_dither_pwm.sv
module frame_dither_pwm
    import fdp_pkg::*;
#(
    parameter int DIV_BITS   = 2,
    parameter int SLOT_BITS  = 5,
    parameter int FRAME_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [SLOT_BITS-1:0] wr_data,
    output logic                 pwm_out,
    output logic                 frame_strobe
);
    logic                  tick;
    logic [DIV_BITS-1:0]   div_code;
    logic [SLOT_BITS-1:0]  act_duty;
    logic [FRAME_BITS-1:0] act_fine;
    logic [SLOT_BITS-1:0]  eff_duty;
    logic [FRAME_BITS-1:0] eff_fine;
    logic [SLOT_BITS-1:0]  slot_nx;
    logic [FRAME_BITS-1:0] frm_nx;
    logic                  frame_open;
    logic                  group_load;
    wave_state_e           st;

    fdp_prescaler #(.DIV_BITS(DIV_BITS)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_code (div_code),
        .tick     (tick)
    );

    fdp_regs #(.DIV_BITS(DIV_BITS), .SLOT_BITS(SLOT_BITS), .FRAME_BITS(FRAME_BITS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .group_load (group_load),
        .div_code   (div_code),
        .act_duty   (act_duty),
        .act_fine   (act_fine),
        .eff_duty   (eff_duty),
        .eff_fine   (eff_fine)
    );

    fdp_seq #(.SLOT_BITS(SLOT_BITS), .FRAME_BITS(FRAME_BITS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .slot_nx    (slot_nx),
        .frm_nx     (frm_nx),
        .frame_open (frame_open),
        .group_load (group_load)
    );

    fdp_wave #(.SLOT_BITS(SLOT_BITS), .FRAME_BITS(FRAME_BITS)) u_wave (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .frame_open   (frame_open),
        .slot_nx      (slot_nx),
        .frm_nx       (frm_nx),
        .eff_duty     (eff_duty),
        .eff_fine     (eff_fine),
        .st           (st),
        .pwm_out      (pwm_out),
        .frame_strobe (frame_strobe)
    );
endmodule

// File: rtl/fdp_checker.sv
module fdp_checker
    import fdp_pkg::*;
#(
    parameter int SLOT_BITS  = 5,
    parameter int FRAME_BITS = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic                  group_load,
    input logic [SLOT_BITS-1:0]  act_duty,
    input logic [FRAME_BITS-1:0] act_fine,
    input logic                  pwm_out,
    input logic                  frame_strobe
);
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> !frame_strobe); // R3

    AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |-> $past(tick)); // R2

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2

    AST_RISE_AT_FRAME_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> frame_strobe); // R4

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !group_load |=> ($stable(act_duty) && $stable(act_fine))); // R7

    AST_EMPTY_FRAME_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && act_duty == '0 && act_fine == '0) |-> !pwm_out); // R5
endmodule

bind frame_dither_pwm fdp_checker #(.SLOT_BITS(SLOT_BITS), .FRAME_BITS(FRAME_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .group_load   (group_load),
    .act_duty     (act_duty),
    .act_fine     (act_fine),
    .pwm_out      (pwm_out),
    .frame_strobe (frame_strobe)
);

// File: tb/frame_dither_pwm_tb_top.sv
module frame_dither_pwm_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [4:0] wr_data = 5'd0;
    logic       pwm_out;
    logic       frame_strobe;

    int checks = 0;
    int failures = 0;
    int strobe_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    frame_dither_pwm dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .pwm_out      (pwm_out),
        .frame_strobe (frame_strobe)
    );

    always @(posedge clk) begin
        if (!rst_n) strobe_cnt <= 0;
        else if (frame_strobe) strobe_cnt <= strobe_cnt + 1;
    end

    function automatic int rev3(input int f);
        return ((f & 1) << 2) | (f & 2) | ((f >> 2) & 1);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] sel, input logic [4:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sync_group();
        @(negedge clk);
        while (!(frame_strobe && (strobe_cnt % 8 == 0))) @(negedge clk);
    endtask

    // starts at a negedge where frame_strobe is high, ends at the next such negedge
    task automatic measure_frame(output int per, output int hi);
        per = 0; hi = 0;
        do begin
            per++;
            if (pwm_out) hi++;
            @(negedge clk);
        end while (!frame_strobe);
    endtask

    task automatic check_group(input int duty, input int fine, input int div, input string tag);
        int per, hi, exp_hi;
        sync_group();
        for (int f = 0; f < 8; f++) begin
            measure_frame(per, hi);
            exp_hi = div * (duty + ((rev3(f) < fine) ? 1 : 0));
            check(per == 32 * div, {tag, " period"}, per, 32 * div);
            check(hi == exp_hi, {tag, " high"}, hi, exp_hi);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(pwm_out == 1'b0, "R1 out in reset", pwm_out, 0);
        check(frame_strobe == 1'b0, "R1 strobe in reset", frame_strobe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pwm_out == 1'b0, "R1 out after release", pwm_out, 0);
        check(frame_strobe == 1'b0, "R1 strobe after release", frame_strobe, 0);
    endtask

    task automatic t_empty();
        check_group(0, 0, 2, "R5 R1 cleared fields");
    endtask

    task automatic t_coarse();
        do_write(2'd1, 5'd1);
        check_group(1, 0, 2, "R4 duty1");
        do_write(2'd1, 5'd16);
        check_group(16, 0, 2, "R4 duty16");
        do_write(2'd1, 5'd30);
        check_group(30, 0, 2, "R4 duty30");
    endtask

    task automatic t_dither();
        do_write(2'd1, 5'd16);
        do_write(2'd2, 5'd3);
        check_group(16, 3, 2, "R6 fine3");
        do_write(2'd1, 5'd5);
        do_write(2'd2, 5'd7);
        check_group(5, 7, 2, "R6 fine7");
        do_write(2'd1, 5'd0);
        do_write(2'd2, 5'd1);
        check_group(0, 1, 2, "R6 narrow only");
    endtask

    task automatic t_full();
        do_write(2'd1, 5'd31);
        do_write(2'd2, 5'd7);
        check_group(31, 7, 2, "R8 duty31");
    endtask

    task automatic t_prescale();
        do_write(2'd1, 5'd16);
        do_write(2'd2, 5'd3);
        do_write(2'd0, 5'd1);
        check_group(16, 3, 4, "R2 div4");
        do_write(2'd0, 5'd2);
        check_group(16, 3, 8, "R2 div8");
        do_write(2'd0, 5'd3);
        check_group(16, 3, 16, "R2 div16");
        do_write(2'd0, 5'd0);
        check_group(16, 3, 2, "R2 div2");
    endtask

    task automatic t_buffered();
        int per, hi;
        do_write(2'd1, 5'd10);
        do_write(2'd2, 5'd0);
        check_group(10, 0, 2, "R7 base");
        sync_group();
        measure_frame(per, hi);
        do_write(2'd1, 5'd20);
        while (!frame_strobe) @(negedge clk);
        measure_frame(per, hi);
        check(hi == 20, "R7 old duty kept", hi, 20);
        check_group(20, 0, 2, "R7 new group");
    endtask

    task automatic t_ignored();
        do_write(2'd3, 5'd31);
        check_group(20, 0, 2, "R9 select 3");
    endtask

    task automatic t_reset_clears();
        do_write(2'd0, 5'd1);
        do_write(2'd2, 5'd5);
        repeat (20) @(negedge clk);
        t_reset();
        check_group(0, 0, 2, "R1 clears after run");
    endtask

    initial begin
        t_reset();
        t_empty();
        t_coarse();
        t_dither();
        t_full();
        t_prescale();
        t_buffered();
        t_ignored();
        t_reset_clears();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule